// File: doc/BRIEF.md
# Mask-Addressed GPIO Bank Register Block

This block holds the control state for one bank of general-purpose I/O lines. Each line has its own configuration word. That word sets the line's function, its direction, its bias resistors, its input glitch filter, open-drain drive, the input threshold mode and an event-type code. The configuration words are not given addresses of their own. Software first writes a line-select mask. Each later write to the configuration offset lands in every line named by that mask, so a single bus write can configure any group of lines at once. A read of the configuration offset returns the word of one selected line.

Output levels are never written directly. One register sets latches and another clears them, and a 1 bit in either acts on the matching line. Two status offsets return the current output latches and the pad levels. The pad levels first pass through a two-stage synchronizer. All per-line settings leave the block as plain control vectors for the pad ring, the input filters and the event logic, which are built elsewhere.

The bus is a simple strobe interface with word offsets inside a 64-byte bank window. A write takes effect at the clock edge that samples it. Read data is registered and valid from the edge that samples the read strobe, and holds until the next read.

Top module: `gpb_bank_regs`

## Requirements
- R1: After reset the select mask is zero, every configuration word is zero, all output latches are low, and every per-line control output is zero.
- R2: A write to byte offset 0x00 replaces the select mask, and a read of 0x00 returns it, with bit n selecting line n.
- R3: A write to offset 0x04 loads the written word into every line whose mask bit is set. Lines whose mask bit is clear keep their word, and a write under an all-zero mask changes nothing. The per-line outputs carry these fields: function select in bits [2:0], direction (1 = drive) in bit 8, pull-up in bit 9, pull-down in bit 10, filter enable in bit 12, slow filter clock in bit 13, open drain in bit 14, threshold mode in bit 15 and event code in bits [26:24].
- R4: A read of offset 0x04 returns the word of the lowest-numbered line selected by the mask, or zero when the mask is zero.
- R5: Configuration bits outside the listed fields are not stored and read back as zero.
- R6: A write to offset 0x10 drives high the output latch of every line whose data bit is 1. Lines with a 0 bit keep their level.
- R7: A write to offset 0x14 drives low the output latch of every line whose data bit is 1. Lines with a 0 bit keep their level.
- R8: A read of offset 0x18 returns the output latches, which are also driven on the line output vector.
- R9: A read of offset 0x08 returns the pad levels after two synchronizer stages. A level present before clock edge k is returned by reads sampled at edge k+2 or later, and a read sampled at edge k+1 still returns the previous level.
- R10: Offset 0x0C and all offsets from 0x1C upward read as zero. Writes to them, and to the read-only offsets 0x08 and 0x18, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset inside the bank window (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, updated on each read |
| pad_in | input | NL | Asynchronous pad levels |
| line_func | output | 3*NL | Function select, 3 bits per line, line n at [3n+2:3n] |
| line_dir | output | NL | Drive enable per line |
| line_pu | output | NL | Pull-up enable per line |
| line_pd | output | NL | Pull-down enable per line |
| line_filt | output | NL | Input filter enable per line |
| line_filt_slow | output | NL | Filter slow-clock select per line |
| line_od | output | NL | Open-drain enable per line |
| line_schmitt | output | NL | Input threshold mode per line |
| line_evt | output | 3*NL | Event code, 3 bits per line, line n at [3n+2:3n] |
| line_out | output | NL | Output latch per line |

## Verification
The block produces results with three different delays. A register write shows on the control outputs just after the clock edge that samples it. Read data is due just after the edge that samples the read strobe. A pad level needs two synchronizer edges before a read can capture it. The bench drives on falling edges and checks the control outputs on the falling edge after a write. Each read puts its expected word into a scoreboard queue, and a monitor compares that word one falling edge after the edge that took the read strobe. The synchronizer delay is checked on both sides of its boundary: one read lands too early and must still see the old pad level, and a later read must see the new one.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    IX_MASK = 4'd0,
    IX_CFG  = 4'd1,
    IX_PIN  = 4'd2,
    IX_LOCK = 4'd3,
    IX_SETO = 4'd4,
    IX_CLRO = 4'd5,
    IX_OUTS = 4'd6
  } reg_idx_e;

  localparam int unsigned FLD_FUNC_LO = 0;
  localparam int unsigned FLD_DIR     = 8;
  localparam int unsigned FLD_PU      = 9;
  localparam int unsigned FLD_PD      = 10;
  localparam int unsigned FLD_FILT    = 12;
  localparam int unsigned FLD_FSLOW   = 13;
  localparam int unsigned FLD_OD      = 14;
  localparam int unsigned FLD_SCHM    = 15;
  localparam int unsigned FLD_EVT_LO  = 24;
  localparam int unsigned CODE_W      = 3;

  localparam logic [WORD_W-1:0] CFG_KEEP = 32'h0700_F707;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpb_out_latch.sv
module gpb_out_latch #(
  parameter int unsigned NL = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [NL-1:0] bits,
  output logic [NL-1:0] lvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
    end else if (set_en) begin
      lvl <= lvl | bits;
    end else if (clr_en) begin
      lvl <= lvl & ~bits;
    end
  end
endmodule

// File: rtl/gpb_cfg_store.sv
module gpb_cfg_store
  import gpb_pkg::*;
#(
  parameter int unsigned NL = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [NL-1:0]            sel,
  output logic [NL-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]        rd_word
);
  for (genvar n = 0; n < NL; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        words[n] <= '0;
      end else if (wr_en && sel[n]) begin
        words[n] <= wdata & CFG_KEEP;
      end
    end
  end

  // lowest selected line wins; empty selection yields zero
  always_comb begin
    rd_word = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (sel[i]) rd_word = words[i];
    end
  end
endmodule

// File: rtl/gpb_bank_regs.sv
module gpb_bank_regs
  import gpb_pkg::*;
#(
  parameter int unsigned NL = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NL-1:0]       pad_in,
  output logic [NL*CODE_W-1:0] line_func,
  output logic [NL-1:0]       line_dir,
  output logic [NL-1:0]       line_pu,
  output logic [NL-1:0]       line_pd,
  output logic [NL-1:0]       line_filt,
  output logic [NL-1:0]       line_filt_slow,
  output logic [NL-1:0]       line_od,
  output logic [NL-1:0]       line_schmitt,
  output logic [NL*CODE_W-1:0] line_evt,
  output logic [NL-1:0]       line_out
);
  localparam int unsigned PAD_W = WORD_W - NL;

  logic [IDX_W-1:0]          idx;
  logic [NL-1:0]             sel_mask;
  logic [NL-1:0]             pad_s;
  logic [NL-1:0][WORD_W-1:0] cfg_words;
  logic [WORD_W-1:0]         cfg_rd;
  logic                      wr_mask, wr_cfg, wr_set, wr_clr;
  logic [WORD_W-1:0]         rd_mux;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_mask = bus_wr && (idx == IX_MASK);
  assign wr_cfg  = bus_wr && (idx == IX_CFG);
  assign wr_set  = bus_wr && (idx == IX_SETO);
  assign wr_clr  = bus_wr && (idx == IX_CLRO);

  always_ff @(posedge clk) begin
    if (rst) sel_mask <= '0;
    else if (wr_mask) sel_mask <= bus_wdata[NL-1:0];
  end

  gpb_sync #(.W(NL)) u_sync (
    .clk(clk), .rst(rst), .d_async(pad_in), .d_sync(pad_s)
  );

  gpb_cfg_store #(.NL(NL)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_cfg), .wdata(bus_wdata),
    .sel(sel_mask), .words(cfg_words), .rd_word(cfg_rd)
  );

  gpb_out_latch #(.NL(NL)) u_out (
    .clk(clk), .rst(rst), .set_en(wr_set), .clr_en(wr_clr),
    .bits(bus_wdata[NL-1:0]), .lvl(line_out)
  );

  for (genvar n = 0; n < NL; n++) begin : g_fan
    assign line_func[n*CODE_W +: CODE_W] = cfg_words[n][FLD_FUNC_LO +: CODE_W];
    assign line_evt[n*CODE_W +: CODE_W]  = cfg_words[n][FLD_EVT_LO +: CODE_W];
    assign line_dir[n]       = cfg_words[n][FLD_DIR];
    assign line_pu[n]        = cfg_words[n][FLD_PU];
    assign line_pd[n]        = cfg_words[n][FLD_PD];
    assign line_filt[n]      = cfg_words[n][FLD_FILT];
    assign line_filt_slow[n] = cfg_words[n][FLD_FSLOW];
    assign line_od[n]        = cfg_words[n][FLD_OD];
    assign line_schmitt[n]   = cfg_words[n][FLD_SCHM];
  end

  function automatic logic [WORD_W-1:0] widen(input logic [NL-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    r[NL-1:0] = v;
    return r;
  endfunction

  always_comb begin
    unique case (idx)
      IX_MASK: rd_mux = widen(sel_mask);
      IX_CFG:  rd_mux = cfg_rd;
      IX_PIN:  rd_mux = widen(pad_s);
      IX_OUTS: rd_mux = widen(line_out);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  if (PAD_W > WORD_W) begin : g_bad_width
    initial $error("NL must not exceed the bus width");
  end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpb_pkg::*;
#(
  parameter int unsigned NL = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [NL-1:0]     sel_mask,
  input logic [NL-1:0]     line_dir,
  input logic [NL-1:0]     line_out
);
  logic [IDX_W-1:0] ix;
  logic             seto_w, clro_w, cfg_w, quiet_r;
  assign ix      = bus_addr[ADDR_W-1:2];
  assign seto_w  = bus_wr && (ix == IX_SETO);
  assign clro_w  = bus_wr && (ix == IX_CLRO);
  assign cfg_w   = bus_wr && (ix == IX_CFG);
  assign quiet_r = bus_rd && (ix == IX_LOCK || ix > IX_OUTS);

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    seto_w |=> ((line_out & $past(bus_wdata[NL-1:0])) == $past(bus_wdata[NL-1:0]))); // R6
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    clro_w |=> ((line_out & $past(bus_wdata[NL-1:0])) == '0)); // R7
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(seto_w || clro_w) |=> $stable(line_out)); // R6
  AST_CFG_UNSELECTED_KEEP: assert property (@(posedge clk) disable iff (rst)
    cfg_w |=> (((line_dir ^ $past(line_dir)) & ~$past(sel_mask)) == '0)); // R3
  AST_CFG_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !cfg_w |=> $stable(line_dir)); // R3
  AST_EMPTY_MASK_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ix == IX_CFG && sel_mask == '0) |=> (bus_rdata == '0)); // R4
  AST_QUIET_READ: assert property (@(posedge clk) disable iff (rst)
    quiet_r |=> (bus_rdata == '0)); // R10
endmodule

bind gpb_bank_regs gpb_checker #(.NL(NL)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sel_mask(sel_mask), .line_dir(line_dir), .line_out(line_out)
);

// File: tb/gpb_bank_regs_test.sv
module gpb_bank_regs_test;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned NL = 32;

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NL-1:0] pad_in = '0;
  logic [NL*3-1:0] line_func, line_evt;
  logic [NL-1:0] line_dir, line_pu, line_pd, line_filt, line_filt_slow;
  logic [NL-1:0] line_od, line_schmitt, line_out;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  gpb_bank_regs #(.NL(NL)) uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  // driver: push expectation, issue strobe
  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  // monitor: data due one falling edge after the sampling edge
  initial forever begin
    @(posedge clk);
    if (bus_rd) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("scoreboard underflow", bus_rdata, 32'hx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(PERIOD*200000);
    check("watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 out", line_out, 0);
    check("R1 dir", line_dir, 0);
    check("R1 pu", line_pu, 0);
    rd(6'h00, 0, "R1 mask");
    rd(6'h04, 0, "R1 cfg");
    rd(6'h18, 0, "R1 outs");

    wr(6'h00, 32'h0000_00F0);
    rd(6'h00, 32'h0000_00F0, "R2 mask");

    wr(6'h04, 32'h0000_0102);
    check("R3 dir group", line_dir, 32'h0000_00F0);
    check("R3 func line4", {29'd0, line_func[14:12]}, 2);
    check("R3 func line3", {29'd0, line_func[11:9]}, 0);

    wr(6'h00, 32'h0000_0001);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, 32'h0700_F707, "R5 undefined bits");
    check("R3 dir", line_dir, 32'h0000_00F1);
    check("R3 flags line0", {24'd0, line_pu[0], line_pd[0], line_filt[0], line_filt_slow[0],
          line_od[0], line_schmitt[0], 2'b00}, 32'h0000_00FC);
    check("R3 evt line0", {29'd0, line_evt[2:0]}, 7);
    check("R3 func line0", {29'd0, line_func[2:0]}, 7);

    wr(6'h00, 32'h0000_0030);
    rd(6'h04, 32'h0000_0102, "R4 lowest line4");
    wr(6'h00, 32'h0000_0031);
    rd(6'h04, 32'h0700_F707, "R4 lowest line0");
    wr(6'h00, 32'h0000_0000);
    rd(6'h04, 32'h0000_0000, "R4 empty mask");
    wr(6'h04, 32'h0000_0000);
    check("R3 empty mask write", line_dir, 32'h0000_00F1);

    wr(6'h00, 32'h8000_0000);
    wr(6'h04, 32'h0400_4000);
    rd(6'h04, 32'h0400_4000, "R4 line31");
    check("R3 od", line_od, 32'h8000_0001);
    check("R3 evt line31", {29'd0, line_evt[95:93]}, 4);

    wr(6'h10, 32'h0000_00A5);
    check("R6 set", line_out, 32'h0000_00A5);
    rd(6'h18, 32'h0000_00A5, "R8 outs");
    wr(6'h10, 32'h0000_0000);
    check("R6 zero set", line_out, 32'h0000_00A5);
    wr(6'h14, 32'h0000_0005);
    check("R7 clear", line_out, 32'h0000_00A0);
    wr(6'h14, 32'h0000_0000);
    rd(6'h18, 32'h0000_00A0, "R7 zero clear");

    @(negedge clk); pad_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rd(6'h08, 32'h1234_5678, "R9 pins");
    @(negedge clk); pad_in = 32'hCAFE_0001;
    rd(6'h08, 32'h1234_5678, "R9 too early");
    rd(6'h08, 32'hCAFE_0001, "R9 settled");

    rd(6'h0C, 0, "R10 lock");
    rd(6'h3C, 0, "R10 unmapped");
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h00, 32'h8000_0000, "R10 mask kept");
    rd(6'h18, 32'h0000_00A0, "R10 outs kept");
    rd(6'h04, 32'h0400_4000, "R10 cfg kept");
    check("R10 dir kept", line_dir, 32'h0000_00F1);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule